// File: doc/BRIEF.md
# LPC and FWH Cycle Header Decoder

This block watches a 4-bit multiplexed flash bus together with its active-low frame strobe and decodes the header of each memory cycle. On every clock where the strobe is low, the nibble on the bus is taken as a start code. The start code decides which of two header formats follows:

- **Firmware-hub format:** one device-select nibble, then seven address nibbles.
- **Standard LPC format:** one cycle-type/direction nibble, then eight address nibbles.

When the last address nibble arrives, the block pulses a header-valid output for one clock. Along with the pulse it presents a protocol flag, a read/write flag, the device-select value and the address, zero-extended to 32 bits. These fields stay unchanged until the next pulse.

A two-bit enable input chooses which formats the target answers: LPC only, firmware-hub only, both, or neither. A 4-bit device identity sets which firmware-hub device-select value is accepted. Turnaround, sync and data phases are handled elsewhere.

Top module: `lpc_fwh_hdr_dec`

## Requirements
- R1: While reset is high, and on the first clock after it, hdr_valid, is_fwh, is_write, dsel and addr are all zero.
- R2: A start nibble of 4'b1101 begins a firmware-hub read, and 4'b1110 begins a firmware-hub write. The accepted header reports is_fwh=1, with is_write=0 for a read and is_write=1 for a write.
- R3: On a firmware-hub cycle, the nibble after the start code is a device-select value. The header is accepted only if this value equals dev_id, and then dsel reports it. Any other value returns the block to idle with no pulse. An accepted LPC header reports dsel=0.
- R4: A firmware-hub header carries seven address nibbles, most significant first. addr[27:0] holds them and addr[31:28] is zero.
- R5: A start nibble of 4'b0000 begins an LPC cycle. The type nibble 3'b010x is a memory read and 3'b011x is a memory write (is_write=1). Bit 0 of the type nibble has no effect, and is_fwh=0.
- R6: An LPC type nibble outside 3'b01xx returns the block to idle with no pulse.
- R7: An LPC header carries eight address nibbles, most significant first, which fill addr[31:0].
- R8: proto_sel[0] enables LPC headers and proto_sel[1] enables firmware-hub headers. A start code of a disabled format yields no pulse and leaves all outputs unchanged.
- R9: The nibble of the last clock with frame_n low is the start code. A frame_n low in the middle of a header abandons that header and starts decoding again.
- R10: hdr_valid is high for exactly the clock after the edge that samples the last address nibble. The other outputs change only together with a pulse.
- R11: A start nibble other than 4'b0000, 4'b1101 or 4'b1110 yields no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low frame strobe |
| bus_nib | input | 4 | Multiplexed bus nibble |
| proto_sel | input | 2 | Format enables: bit 0 LPC, bit 1 firmware hub |
| dev_id | input | 4 | Accepted firmware-hub device-select value |
| hdr_valid | output | 1 | One-clock header-accepted pulse |
| is_fwh | output | 1 | 1 = firmware-hub header, 0 = LPC header |
| is_write | output | 1 | 1 = write, 0 = read |
| dsel | output | 4 | Captured device-select value (0 for LPC) |
| addr | output | 32 | Captured address, zero-extended |

## Verification
The hardest situation to reach is a restart that comes in the middle of a header. This covers a frame strobe that drops partway through the address nibbles, and a strobe held low over several different start nibbles. Only the final nibble may count in either case, and no pulse may leak from the abandoned header. The stimulus builds these cases directly: it cuts a firmware-hub header after three address nibbles and restarts it as an LPC header, and it holds the strobe across a firmware-hub start code followed by an LPC start code. It also runs back-to-back headers with no idle gap, so that one-cycle pulses and held fields can be told apart.

// File: rtl/lfh_pkg.sv
package lfh_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FWH_SEL,
    ST_LPC_TYPE,
    ST_ADDR
  } hdr_state_t;

  localparam logic [NIB_W-1:0] START_LPC    = 4'b0000;
  localparam logic [NIB_W-1:0] START_FWH_RD = 4'b1101;
  localparam logic [NIB_W-1:0] START_FWH_WR = 4'b1110;
  localparam logic [2:0]       TYPE_MEM_RD  = 3'b010;
  localparam logic [2:0]       TYPE_MEM_WR  = 3'b011;
endpackage

// File: rtl/lfh_start_decode.sv
module lfh_start_decode
  import lfh_pkg::*;
(
  input  logic [NIB_W-1:0] nib,
  input  logic             lpc_en,
  input  logic             fwh_en,
  output logic             go_lpc,
  output logic             go_fwh,
  output logic             fwh_wr
);
  always_comb begin
    go_lpc = lpc_en && (nib == START_LPC);
    go_fwh = fwh_en && ((nib == START_FWH_RD) || (nib == START_FWH_WR));
    fwh_wr = (nib == START_FWH_WR);
  end
endmodule

// File: rtl/lfh_addr_shift.sv
module lfh_addr_shift #(
  parameter int ADDR_W = 32,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic [NIB_W-1:0]  nib,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] acc;

  assign nxt = {acc[ADDR_W-NIB_W-1:0], nib};

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (en)    acc <= nxt;
  end
endmodule

// File: rtl/lfh_hdr_fsm.sv
module lfh_hdr_fsm
  import lfh_pkg::*;
#(
  parameter int FWH_NIBS = 7,
  parameter int LPC_NIBS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n,
  input  logic [NIB_W-1:0] nib,
  input  logic             go_lpc,
  input  logic             go_fwh,
  input  logic             fwh_wr,
  input  logic [NIB_W-1:0] dev_id,
  output logic             shift_clr,
  output logic             shift_en,
  output logic             done,
  output logic             cur_fwh,
  output logic             cur_wr,
  output logic [NIB_W-1:0] cur_dsel
);
  localparam int CNT_W = $clog2(LPC_NIBS + 1);

  hdr_state_t       state;
  logic [CNT_W-1:0] cnt;

  assign shift_clr = !frame_n;
  assign shift_en  = frame_n && (state == ST_ADDR);
  assign done      = shift_en && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      cur_fwh  <= 1'b0;
      cur_wr   <= 1'b0;
      cur_dsel <= '0;
    end else if (!frame_n) begin
      cnt      <= '0;
      cur_dsel <= '0;
      if (go_fwh) begin
        state   <= ST_FWH_SEL;
        cur_fwh <= 1'b1;
        cur_wr  <= fwh_wr;
      end else if (go_lpc) begin
        state   <= ST_LPC_TYPE;
        cur_fwh <= 1'b0;
        cur_wr  <= 1'b0;
      end else begin
        state <= ST_IDLE;
      end
    end else begin
      case (state)
        ST_FWH_SEL: begin
          if (nib == dev_id) begin
            state    <= ST_ADDR;
            cnt      <= CNT_W'(FWH_NIBS);
            cur_dsel <= nib;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_LPC_TYPE: begin
          if (nib[3:1] == TYPE_MEM_RD || nib[3:1] == TYPE_MEM_WR) begin
            state  <= ST_ADDR;
            cnt    <= CNT_W'(LPC_NIBS);
            cur_wr <= nib[1];
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_ADDR: begin
          cnt <= cnt - CNT_W'(1);
          if (cnt == CNT_W'(1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: the nibble counter stays inside the longest header while addressing
  assert_cnt_range_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR) |-> (cnt >= CNT_W'(1) && cnt <= CNT_W'(LPC_NIBS)));

  // R9: a low strobe never leaves the machine in the address phase
  assert_frame_restart_R9: assert property (@(posedge clk) disable iff (rst)
    !frame_n |=> (state != ST_ADDR));

  // R6: a type nibble outside the memory group drops back to idle
  assert_bad_type_R6: assert property (@(posedge clk) disable iff (rst)
    (frame_n && state == ST_LPC_TYPE && nib[3:2] != 2'b01) |=> (state == ST_IDLE));
endmodule

// File: rtl/lpc_fwh_hdr_dec.sv
module lpc_fwh_hdr_dec
  import lfh_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int FWH_NIBS = 7,
  parameter int LPC_NIBS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n,
  input  logic [3:0]        bus_nib,
  input  logic [1:0]        proto_sel,
  input  logic [3:0]        dev_id,
  output logic              hdr_valid,
  output logic              is_fwh,
  output logic              is_write,
  output logic [3:0]        dsel,
  output logic [ADDR_W-1:0] addr
);
  logic go_lpc, go_fwh, fwh_wr;
  logic shift_clr, shift_en, done, cur_fwh, cur_wr;
  logic [NIB_W-1:0]  cur_dsel;
  logic [ADDR_W-1:0] addr_nxt;

  lfh_start_decode u_start (
    .nib(bus_nib), .lpc_en(proto_sel[0]), .fwh_en(proto_sel[1]),
    .go_lpc(go_lpc), .go_fwh(go_fwh), .fwh_wr(fwh_wr)
  );

  lfh_hdr_fsm #(.FWH_NIBS(FWH_NIBS), .LPC_NIBS(LPC_NIBS)) u_fsm (
    .clk(clk), .rst(rst), .frame_n(frame_n), .nib(bus_nib),
    .go_lpc(go_lpc), .go_fwh(go_fwh), .fwh_wr(fwh_wr), .dev_id(dev_id),
    .shift_clr(shift_clr), .shift_en(shift_en), .done(done),
    .cur_fwh(cur_fwh), .cur_wr(cur_wr), .cur_dsel(cur_dsel)
  );

  lfh_addr_shift #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_shift (
    .clk(clk), .rst(rst), .clr(shift_clr), .en(shift_en),
    .nib(bus_nib), .nxt(addr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_valid <= 1'b0;
      is_fwh    <= 1'b0;
      is_write  <= 1'b0;
      dsel      <= '0;
      addr      <= '0;
    end else begin
      hdr_valid <= done;
      if (done) begin
        is_fwh   <= cur_fwh;
        is_write <= cur_wr;
        dsel     <= cur_dsel;
        addr     <= addr_nxt;
      end
    end
  end

  // R10: every header is longer than one clock, so pulses never touch
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |=> !hdr_valid);

  // R10: fields move only together with a pulse
  assert_fields_stable_R10: assert property (@(posedge clk) disable iff (rst)
    !hdr_valid |-> ($stable(addr) && $stable(dsel) && $stable(is_fwh) && $stable(is_write)));

  // R4: a firmware-hub address is zero-extended
  assert_fwh_addr_width_R4: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && is_fwh) |-> (addr[ADDR_W-1:ADDR_W-4] == 4'h0));

  // R3: LPC headers carry no device-select value
  assert_lpc_no_dsel_R3: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && !is_fwh) |-> (dsel == 4'h0));
endmodule

// File: tb/test_lpc_fwh_hdr_dec.sv
module test_lpc_fwh_hdr_dec;
  logic        clk = 1'b0;
  logic        rst;
  logic        frame_n;
  logic [3:0]  bus_nib;
  logic [1:0]  proto_sel;
  logic [3:0]  dev_id;
  logic        hdr_valid, is_fwh, is_write;
  logic [3:0]  dsel;
  logic [31:0] addr;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;
  string cur_req = "R1";

  // reference model state
  int          m_state;   // 0 idle, 1 select, 2 type, 3 address
  int          m_left;
  bit          m_fwh, m_wr;
  int          m_dsel;
  longint      m_acc;
  bit          e_valid, e_fwh, e_wr;
  int          e_dsel;
  longint      e_addr;

  lpc_fwh_hdr_dec i_lpc_fwh_hdr_dec (
    .clk(clk), .rst(rst), .frame_n(frame_n), .bus_nib(bus_nib),
    .proto_sel(proto_sel), .dev_id(dev_id), .hdr_valid(hdr_valid),
    .is_fwh(is_fwh), .is_write(is_write), .dsel(dsel), .addr(addr)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog: act=%0d cycles exp<=20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    int n;
    n = int'(bus_nib);
    e_valid = 0;
    if (rst) begin
      m_state = 0; m_left = 0; m_fwh = 0; m_wr = 0; m_dsel = 0; m_acc = 0;
      e_fwh = 0; e_wr = 0; e_dsel = 0; e_addr = 0;
    end else if (!frame_n) begin
      m_acc = 0; m_dsel = 0; m_left = 0;
      if ((n == 13 || n == 14) && proto_sel[1]) begin
        m_state = 1; m_fwh = 1; m_wr = (n == 14);
      end else if (n == 0 && proto_sel[0]) begin
        m_state = 2; m_fwh = 0; m_wr = 0;
      end else m_state = 0;
    end else if (m_state == 1) begin
      if (n == int'(dev_id)) begin m_state = 3; m_left = 7; m_dsel = n; end
      else m_state = 0;
    end else if (m_state == 2) begin
      if (n / 2 == 2)      begin m_state = 3; m_left = 8; m_wr = 0; end
      else if (n / 2 == 3) begin m_state = 3; m_left = 8; m_wr = 1; end
      else m_state = 0;
    end else if (m_state == 3) begin
      m_acc = ((m_acc * 16) + n) % 64'h1_0000_0000;
      m_left--;
      if (m_left == 0) begin
        m_state = 0;
        e_valid = 1; e_fwh = m_fwh; e_wr = m_wr; e_dsel = m_dsel; e_addr = m_acc;
      end
    end
  endtask

  task automatic cyc(input logic fr, input logic [3:0] n);
    frame_n = fr;
    bus_nib = n;
    model_step();
    @(negedge clk);
    chk({cur_req, " hdr_valid"}, hdr_valid, e_valid);
    chk({cur_req, " is_fwh"},    is_fwh,    e_fwh);
    chk({cur_req, " is_write"},  is_write,  e_wr);
    chk({cur_req, " dsel"},      dsel,      e_dsel);
    chk({cur_req, " addr"},      addr,      e_addr);
  endtask

  task automatic fwh_hdr(input bit wr, input logic [3:0] sel, input logic [27:0] a, input bit ok);
    cyc(1'b0, wr ? 4'b1110 : 4'b1101);
    cyc(1'b1, sel);
    for (int i = 6; i >= 0; i--) cyc(1'b1, a[i*4 +: 4]);
    chk({cur_req, " fwh pulse"}, hdr_valid, ok);
    if (ok) begin
      chk("R2 fwh flag", is_fwh, 1);
      chk("R2 fwh dir", is_write, wr);
      chk("R3 dsel", dsel, sel);
      chk("R4 fwh addr", addr, {4'h0, a});
    end
  endtask

  task automatic lpc_hdr(input logic [3:0] typ, input logic [31:0] a, input bit ok);
    cyc(1'b0, 4'b0000);
    cyc(1'b1, typ);
    for (int i = 7; i >= 0; i--) cyc(1'b1, a[i*4 +: 4]);
    chk({cur_req, " lpc pulse"}, hdr_valid, ok);
    if (ok) begin
      chk("R5 lpc flag", is_fwh, 0);
      chk("R5 lpc dir", is_write, typ[1]);
      chk("R3 lpc dsel", dsel, 0);
      chk("R7 lpc addr", addr, a);
    end
  endtask

  initial begin
    rst = 1'b1; frame_n = 1'b1; bus_nib = 4'h0; proto_sel = 2'b11; dev_id = 4'h5;
    cur_req = "R1";
    repeat (3) cyc(1'b1, 4'h0);
    rst = 1'b0;
    cyc(1'b1, 4'h0);
    chk("R1 reset addr", addr, 0);
    chk("R1 reset valid", hdr_valid, 0);

    cur_req = "R2";  fwh_hdr(0, 4'h5, 28'hABCDEF1, 1); cyc(1'b1, 4'h0);
    cur_req = "R2";  fwh_hdr(1, 4'h5, 28'h1234567, 1); cyc(1'b1, 4'h0);
    cur_req = "R3";  fwh_hdr(0, 4'h6, 28'h7654321, 0); cyc(1'b1, 4'h0);
    chk("R3 addr held", addr, 32'h01234567);
    dev_id = 4'hF;
    cur_req = "R4";  fwh_hdr(1, 4'hF, 28'hFFFFFFF, 1); cyc(1'b1, 4'h0);

    cur_req = "R5";  lpc_hdr(4'b0100, 32'hDEADBEEF, 1);
    cur_req = "R5";  lpc_hdr(4'b0101, 32'h00000001, 1);
    cur_req = "R5";  lpc_hdr(4'b0110, 32'h80000000, 1);
    cur_req = "R7";  lpc_hdr(4'b0111, 32'hC0FFEE42, 1);
    cur_req = "R6";  lpc_hdr(4'b0010, 32'h11111111, 0);
    cur_req = "R6";  lpc_hdr(4'b1000, 32'h22222222, 0);
    chk("R6 addr held", addr, 32'hC0FFEE42);

    proto_sel = 2'b01;
    cur_req = "R8";  fwh_hdr(0, 4'hF, 28'h0333333, 0);
    chk("R8 addr held", addr, 32'hC0FFEE42);
    cur_req = "R8";  lpc_hdr(4'b0100, 32'h44444444, 1);
    proto_sel = 2'b10;
    cur_req = "R8";  lpc_hdr(4'b0100, 32'h55555555, 0);
    chk("R8 addr held", addr, 32'h44444444);
    cur_req = "R8";  fwh_hdr(1, 4'hF, 28'h0666666, 1);
    proto_sel = 2'b00;
    cur_req = "R8";  lpc_hdr(4'b0110, 32'h77777777, 0);
    proto_sel = 2'b11;

    cur_req = "R11";
    cyc(1'b0, 4'b0011); cyc(1'b1, 4'b0100);
    for (int i = 0; i < 8; i++) cyc(1'b1, 4'h9);
    chk("R11 addr held", addr, 32'h00666666);

    cur_req = "R9";
    cyc(1'b0, 4'b1101); lpc_hdr(4'b0100, 32'h89ABCDEF, 1);
    cur_req = "R9";
    cyc(1'b0, 4'b1110); cyc(1'b1, 4'hF);
    for (int i = 0; i < 3; i++) cyc(1'b1, 4'hA);
    lpc_hdr(4'b0110, 32'h13572468, 1);

    cur_req = "R10";
    lpc_hdr(4'b0100, 32'hAAAA5555, 1);
    fwh_hdr(0, 4'hF, 28'h0BBBBBB, 1);
    lpc_hdr(4'b0111, 32'h5A5A5A5A, 1);
    cyc(1'b1, 4'h3);
    chk("R10 pulse ends", hdr_valid, 0);
    chk("R10 addr held", addr, 32'h5A5A5A5A);
    for (int i = 0; i < 4; i++) cyc(1'b1, 4'h0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule